// File: doc/BRIEF.md
# Link Status and Event Flag Register Bank

This block sits beside the master end of a serial encoder link and turns raw condition inputs into two byte-wide registers that the host reads. The first is a link status byte: a connection flag at the top and the current link quality value at the bottom. The second is a high event byte. It holds a mirror of the interrupt line, a live remote-event summary flag and a sticky safe-channel consistency flag.

Event flags come in two kinds. Edge-captured flags latch on the rising edge of their condition. They re-arm only after the condition has gone away. Once set, they stay set until the host clears them by writing ones to a clear mask. Level-following flags track their condition one cycle late and cannot be cleared by the host. The interrupt output is the registered OR of the event flags under a host-written enable mask. The block also emits a single-cycle protocol reset request when link quality drops to zero.

All condition inputs are synchronous to `clk`. Every register output changes one clock edge after the input that caused it, and the interrupt changes one edge after that.

Top module: `lnk_evt_regbank`

## Requirements
- R1: Status bit 7 equals `link_up_i` as sampled at the previous rising clock edge (1 = connection up).
- R2: Status bits 6 to 4 always read as zero.
- R3: Status bits 3 to 0 equal `quality_i` as sampled at the previous rising clock edge.
- R4: `proto_rst_o` is high for exactly one cycle, and that cycle is the one in which status bits 3 to 0 first show 0000. It does not rise again while quality stays at zero. It can only fire again after quality has been sampled non-zero.
- R5: Event bit 5 (safe-channel error) is set one edge after a rising edge of `safe_err_i`. It stays set after `safe_err_i` falls.
- R6: Clearing event bit 5 while `safe_err_i` is held high leaves it clear. Only a fresh low-to-high change of `safe_err_i` sets it again.
- R7: Event bit 6 (remote summary) equals `remote_evt_i` as sampled at the previous edge. A host clear of bit 6 has no effect on it.
- R8: A cycle with `evt_clr_we_i` high clears, at the next edge, each sticky event bit whose `evt_clr_mask_i` bit is 1. Bits whose mask bit is 0 are unchanged. Mask bit k maps to event bit k.
- R9: When a rising edge of `safe_err_i` and a host clear of bit 5 fall in the same cycle, bit 5 ends up set.
- R10: `irq_o` is the registered OR of event bits 6 to 0, each ANDed with the matching enable bit. It follows a flag change by one further edge. Event bit 7 always equals `irq_o`.
- R11: The enable mask resets to all zero and is loaded from `irq_en_i` on a cycle with `irq_en_we_i` high. While a flag's enable bit is 0, that flag cannot raise `irq_o`.
- R12: During reset, both bytes, `irq_o` and `proto_rst_o` are 0. Event bits 4 to 0 always read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_up_i | input | 1 | Connection established condition |
| quality_i | input | 4 | Link quality value, higher is better |
| remote_evt_i | input | 1 | Remote side summary event condition |
| safe_err_i | input | 1 | Safe-channel consistency error condition |
| evt_clr_we_i | input | 1 | Host clear strobe for event flags |
| evt_clr_mask_i | input | 7 | Write-one-to-clear mask for event bits 6..0 |
| irq_en_we_i | input | 1 | Host write strobe for the interrupt enable mask |
| irq_en_i | input | 7 | Interrupt enable value for event bits 6..0 |
| status_o | output | 8 | Link status byte |
| event_o | output | 8 | High event byte |
| irq_o | output | 1 | Registered interrupt request |
| proto_rst_o | output | 1 | One-cycle forced protocol reset request |

## Verification
The hardware set of the sticky safe-channel flag and the host clear of that same flag can land in the same cycle. The bench provokes this by driving a low-to-high change of `safe_err_i` and a clear strobe with bit 5 of the mask set, both on one clock. It then judges the outcome by reading event bit 5 after that edge and expecting it set. A separate case holds the condition high through a clear and expects the bit to stay clear, which shows that the set comes from the edge and not from the level.

// File: rtl/lnk_evt_pkg.sv
package lnk_evt_pkg;

  localparam int QW       = 4;
  localparam int RW       = 8;
  localparam int EVT_SRC  = RW - 1;
  localparam int PAD_W    = RW - 1 - QW;
  localparam int SUM_BIT  = 6;
  localparam int SCE_BIT  = 5;

  typedef enum logic [0:0] {
    FK_EDGE  = 1'b0,
    FK_LEVEL = 1'b1
  } flag_kind_e;

  function automatic flag_kind_e kind_of(input int b);
    return (b == SUM_BIT) ? FK_LEVEL : FK_EDGE;
  endfunction

  function automatic logic rise_bit(input logic cur, input logic prev);
    return cur & ~prev;
  endfunction

  function automatic logic sticky_next(input logic flag, input logic set,
                                       input logic clr);
    return set | (flag & ~clr);
  endfunction

  function automatic logic irq_any(input logic [EVT_SRC-1:0] flags,
                                   input logic [EVT_SRC-1:0] en);
    return |(flags & en);
  endfunction

  function automatic logic [RW-1:0] pack_status(input logic link,
                                                input logic [QW-1:0] q);
    return {link, {PAD_W{1'b0}}, q};
  endfunction

endpackage

// File: rtl/lnk_status_reg.sv
module lnk_status_reg
  import lnk_evt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_i,
  input  logic [QW-1:0] qual_i,
  output logic [RW-1:0] status_o
);

  logic          link_q;
  logic [QW-1:0] qual_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_q <= 1'b0;
      qual_q <= '0;
    end else begin
      link_q <= link_i;
      qual_q <= qual_i;
    end
  end

  assign status_o = pack_status(link_q, qual_q);

  // R1
  link_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_i |=> status_o[RW-1]);

endmodule

// File: rtl/qual_rst_gen.sv
module qual_rst_gen
  import lnk_evt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [QW-1:0] qual_i,
  output logic          pulse_o
);

  logic zero_w;
  logic armed_q;
  logic pulse_q;

  assign zero_w = (qual_i == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= zero_w & armed_q;
      armed_q <= ~zero_w;
    end
  end

  assign pulse_o = pulse_q;

  // R4
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |=> !pulse_o);

  // R4
  no_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_w && !armed_q) |=> !pulse_o);

endmodule

// File: rtl/evt_flag_bank.sv
module evt_flag_bank
  import lnk_evt_pkg::*;
#(
  parameter int N = EVT_SRC
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cond_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_mask_i,
  output logic [N-1:0] flags_o
);

  logic [N-1:0] clr_hit_w;

  assign clr_hit_w = clr_we_i ? clr_mask_i : '0;

  for (genvar i = 0; i < N; i++) begin : g_bit
    if (kind_of(i) == FK_EDGE) begin : g_edge
      logic prev_q;
      logic f_q;
      logic rise_w;

      assign rise_w = rise_bit(cond_i[i], prev_q);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
          f_q    <= 1'b0;
        end else begin
          prev_q <= cond_i[i];
          f_q    <= sticky_next(f_q, rise_w, clr_hit_w[i]);
        end
      end

      assign flags_o[i] = f_q;

      // R5 R9
      edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_w |=> flags_o[i]);

      // R5
      sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o[i] && !clr_hit_w[i]) |=> flags_o[i]);

      // R8
      clr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit_w[i] && !rise_w) |=> !flags_o[i]);
    end else begin : g_level
      logic f_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= 1'b0;
        else        f_q <= cond_i[i];
      end

      assign flags_o[i] = f_q;

      // R7
      lvl_clr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit_w[i] && cond_i[i]) |=> flags_o[i]);

      // R7
      lvl_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_i[i] |=> !flags_o[i]);
    end
  end

endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import lnk_evt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [EVT_SRC-1:0] flags_i,
  input  logic               en_we_i,
  input  logic [EVT_SRC-1:0] en_i,
  output logic               irq_o
);

  logic [EVT_SRC-1:0] en_q;
  logic               irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      if (en_we_i) en_q <= en_i;
      irq_q <= irq_any(flags_i, en_q);
    end
  end

  assign irq_o = irq_q;

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flags_i & en_q)) |=> !irq_o);

  // R11
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(|flags_i));

endmodule

// File: rtl/lnk_evt_regbank.sv
module lnk_evt_regbank
  import lnk_evt_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               link_up_i,
  input  logic [QW-1:0]      quality_i,
  input  logic               remote_evt_i,
  input  logic               safe_err_i,
  input  logic               evt_clr_we_i,
  input  logic [EVT_SRC-1:0] evt_clr_mask_i,
  input  logic               irq_en_we_i,
  input  logic [EVT_SRC-1:0] irq_en_i,
  output logic [RW-1:0]      status_o,
  output logic [RW-1:0]      event_o,
  output logic               irq_o,
  output logic               proto_rst_o
);

  logic [EVT_SRC-1:0] cond_w;
  logic [EVT_SRC-1:0] flags_w;
  logic               irq_w;

  always_comb begin
    cond_w          = '0;
    cond_w[SUM_BIT] = remote_evt_i;
    cond_w[SCE_BIT] = safe_err_i;
  end

  lnk_status_reg u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .link_i   (link_up_i),
    .qual_i   (quality_i),
    .status_o (status_o)
  );

  qual_rst_gen u_qrst (
    .clk     (clk),
    .rst_n   (rst_n),
    .qual_i  (quality_i),
    .pulse_o (proto_rst_o)
  );

  evt_flag_bank #(.N(EVT_SRC)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .cond_i     (cond_w),
    .clr_we_i   (evt_clr_we_i),
    .clr_mask_i (evt_clr_mask_i),
    .flags_o    (flags_w)
  );

  irq_agg u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .flags_i (flags_w),
    .en_we_i (irq_en_we_i),
    .en_i    (irq_en_i),
    .irq_o   (irq_w)
  );

  assign irq_o   = irq_w;
  assign event_o = {irq_w, flags_w};

  // R12
  unused_evt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!remote_evt_i && !safe_err_i) |-> (event_o[SCE_BIT-1:0] == '0));

endmodule

// File: tb/lnk_evt_regbank_tb.sv
module lnk_evt_regbank_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       link_up = 1'b0;
  logic [3:0] quality = 4'hF;
  logic       remote_evt = 1'b0;
  logic       safe_err = 1'b0;
  logic       clr_we = 1'b0;
  logic [6:0] clr_mask = '0;
  logic       en_we = 1'b0;
  logic [6:0] en_val = '0;
  logic [7:0] status;
  logic [7:0] evt;
  logic       irq;
  logic       prst;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  lnk_evt_regbank dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .link_up_i      (link_up),
    .quality_i      (quality),
    .remote_evt_i   (remote_evt),
    .safe_err_i     (safe_err),
    .evt_clr_we_i   (clr_we),
    .evt_clr_mask_i (clr_mask),
    .irq_en_we_i    (en_we),
    .irq_en_i       (en_val),
    .status_o       (status),
    .event_o        (evt),
    .irq_o          (irq),
    .proto_rst_o    (prst)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_evt(input logic i7, input logic s6, input logic e5);
    return {i7, s6, e5, 5'b0};
  endfunction

  task automatic host_clear(input logic [6:0] m);
    clr_we = 1'b1; clr_mask = m;
    step();
    clr_we = 1'b0; clr_mask = '0;
  endtask

  task automatic t_reset();
    chk("R12 status in reset", status, 8'h00);
    chk("R12 event in reset", evt, 8'h00);
    chk("R12 irq/prst in reset", {6'b0, irq, prst}, 8'h00);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_status();
    link_up = 1'b1; quality = 4'h9;
    step();
    chk("R1 R2 R3 status up q9", status, 8'h89);
    link_up = 1'b0; quality = 4'h3;
    step();
    chk("R1 R3 status down q3", status, 8'h03);
    link_up = 1'b1; quality = 4'hF;
    step();
    chk("R2 status pad zero", status & 8'h70, 8'h00);
  endtask

  task automatic t_qual_reset();
    quality = 4'h0;
    step();
    chk("R4 pulse on zero entry", {7'b0, prst}, 8'h01);
    chk("R4 quality shows zero", status & 8'h0F, 8'h00);
    step();
    chk("R4 pulse single cycle", {7'b0, prst}, 8'h00);
    step(); step();
    chk("R4 no repeat at zero", {7'b0, prst}, 8'h00);
    quality = 4'h2;
    step();
    chk("R4 no pulse on rise", {7'b0, prst}, 8'h00);
    quality = 4'h0;
    step();
    chk("R4 pulse after re-arm", {7'b0, prst}, 8'h01);
    quality = 4'h5;
    step();
  endtask

  task automatic t_edge();
    safe_err = 1'b1;
    step();
    chk("R5 set on rise", evt, exp_evt(0, 0, 1));
    host_clear(7'h20);
    chk("R6 cleared while held", evt, exp_evt(0, 0, 0));
    step();
    chk("R6 stays clear while held", evt, exp_evt(0, 0, 0));
    safe_err = 1'b0;
    step();
    safe_err = 1'b1;
    step();
    chk("R6 re-arm sets", evt, exp_evt(0, 0, 1));
    safe_err = 1'b0;
    step();
    chk("R5 sticky after drop", evt, exp_evt(0, 0, 1));
    host_clear(7'h40);
    chk("R8 unmasked bit kept", evt, exp_evt(0, 0, 1));
    host_clear(7'h20);
    chk("R8 masked bit cleared", evt, exp_evt(0, 0, 0));
  endtask

  task automatic t_level();
    remote_evt = 1'b1;
    step();
    chk("R7 level follows", evt, exp_evt(0, 1, 0));
    host_clear(7'h40);
    chk("R7 clear ignored", evt, exp_evt(0, 1, 0));
    remote_evt = 1'b0;
    step();
    chk("R7 level drops", evt, exp_evt(0, 0, 0));
  endtask

  task automatic t_setwins();
    safe_err = 1'b1;
    clr_we = 1'b1; clr_mask = 7'h20;
    step();
    clr_we = 1'b0; clr_mask = '0;
    chk("R9 set beats clear", evt, exp_evt(0, 0, 1));
    safe_err = 1'b0;
    host_clear(7'h20);
    chk("R9 cleanup", evt, exp_evt(0, 0, 0));
  endtask

  task automatic t_irq();
    remote_evt = 1'b1;
    step(); step();
    chk("R11 masked flag no irq", {7'b0, irq}, 8'h00);
    en_we = 1'b1; en_val = 7'h40;
    step();
    en_we = 1'b0; en_val = '0;
    step();
    chk("R10 irq raised", {7'b0, irq}, 8'h01);
    chk("R10 event bit7 mirrors", evt, exp_evt(1, 1, 0));
    remote_evt = 1'b0;
    step();
    chk("R10 irq lags flag", evt, exp_evt(1, 0, 0));
    step();
    chk("R10 irq dropped", evt, exp_evt(0, 0, 0));
    safe_err = 1'b1;
    step(); step();
    chk("R11 other bit disabled", {7'b0, irq}, 8'h00);
    safe_err = 1'b0;
    host_clear(7'h20);
  endtask

  initial begin
    step(); step();
    t_reset();
    t_status();
    t_qual_reset();
    t_edge();
    t_level();
    t_setwins();
    t_irq();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule